// File: doc/BRIEF.md
# Serial Gain Word Port with Power-State Decode

This block is the digital control side of a programmable-gain line amplifier. A host loads an 8-bit gain word over three wires: a serial clock, a serial data line and an active-low load strobe. Bits are taken most significant first on rising serial-clock edges, but only while the strobe is low. The applied gain does not change while the word is being shifted. When the strobe rises, the shifted word moves into a holding latch, and further shifting stops until the strobe falls again. The latched word is limited to the legal code range before it reaches the outputs. The outputs give the code, a signed dB figure and a flag that reports the clamp. A second flag shows whether the last transfer carried exactly eight bits.

Two asynchronous level inputs, a transmit enable and an active-low sleep, set a three-level power state for the analog stages. All five control inputs are external and asynchronous. They are synchronized into the block clock domain, and the serial-clock and strobe edges are detected there. The block clock must run at least four times faster than the serial clock.

Top module: `serial_gain_port`

## Requirements
- R1: After reset the applied gain code is 1, gain_db_o is -28, clamp_o and word_full_o are 0, and the internal shift register is all zeros.
- R2: While load_ni is low, every rising edge of sclk_i shifts sdata_i in at the least significant end, so the first bit ends up as bit 7. On the rising edge of load_ni the register contents become the applied word.
- R3: While load_ni stays low, the applied gain code and gain_db_o keep their previous values, no matter how many serial bits arrive.
- R4: Rising sclk_i edges while load_ni is high have no effect on the shift register.
- R5: A latched word of 0 is applied as code 1, and a latched word above 60 is applied as code 60. In both cases clamp_o is 1. Words from 1 to 60 pass unchanged with clamp_o at 0.
- R6: gain_db_o is a signed two's-complement value equal to the applied code minus 29. It ranges from -28 to +31.
- R7: If load_ni rises after a number of sclk_i edges other than 8, the latch still takes the register as it stands. That is the older contents shifted by the number of bits received, or only the last 8 bits if more than 8 arrived.
- R8: word_full_o becomes 1 at a load only when exactly 8 sclk_i rising edges were seen since the preceding falling edge of load_ni. Otherwise it becomes 0.
- R9: pwr_state_o is 2'b00 (sleep) whenever sleep_ni is 0, whatever tx_en_i is. It is 2'b01 (transmit off) when sleep_ni is 1 and tx_en_i is 0, and 2'b10 (transmit on) when both are 1.
- R10: If an sclk_i rising edge and the load_ni rising edge are seen in the same cycle, that bit is not shifted, and the latch takes the register without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial gain data, MSB first |
| load_ni | input | 1 | Active-low load strobe: low = shift, rising edge = apply |
| tx_en_i | input | 1 | Transmit enable, asynchronous |
| sleep_ni | input | 1 | Active-low sleep, asynchronous, overrides tx_en_i |
| gain_code_o | output | 8 | Applied gain code, 1..60 |
| gain_db_o | output | 8 | Signed gain in dB (code minus 29) |
| clamp_o | output | 1 | Latched word was outside 1..60 |
| word_full_o | output | 1 | Last load carried exactly 8 bits |
| pwr_state_o | output | 2 | 00 sleep, 01 transmit off, 10 transmit on |

## Verification
A serial-clock rising edge and the strobe rising edge can be detected in the same block cycle. When that happens, the block must decide whether the bit lands before the latch is loaded. The bench provokes this by shifting seven bits and then raising sclk_i and load_ni on the same driving edge, so both pass through identical synchronizers. The test passes only if the applied word is the register with seven new bits, so the eighth bit is left out, and word_full_o reads 0.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int unsigned WORD_W_DEF = 8;
  localparam int unsigned CODE_MIN_DEF = 1;
  localparam int unsigned CODE_MAX_DEF = 60;
  localparam int unsigned DB_OFFSET_DEF = 29;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    PWR_SLEEP  = 2'b00,
    PWR_TX_OFF = 2'b01,
    PWR_TX_ON  = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int unsigned N = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sgc_shift.sv
module sgc_shift #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  // count saturates one past a full word so "more than a word" stays distinct
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i) cnt_q <= shift_i ? CNT_W'(1) : '0;
    else if (shift_i && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign word_o  = sr_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/sgc_latch.sv
module sgc_latch #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned CODE_MIN = 1,
  parameter int unsigned CODE_MAX = 60,
  parameter int unsigned DB_OFFSET = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              full_i,
  output logic [WORD_W-1:0] code_o,
  output logic [WORD_W-1:0] db_o,
  output logic              clamp_o,
  output logic              full_o
);
  localparam logic [WORD_W-1:0] MIN_C = WORD_W'(CODE_MIN);
  localparam logic [WORD_W-1:0] MAX_C = WORD_W'(CODE_MAX);
  localparam logic [WORD_W-1:0] OFF_C = WORD_W'(DB_OFFSET);

  logic [WORD_W-1:0] raw_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= MIN_C;
      full_q <= 1'b0;
    end else if (load_i) begin
      raw_q  <= word_i;
      full_q <= full_i;
    end
  end

  always_comb begin
    clamp_o = 1'b0;
    code_o  = raw_q;
    if (raw_q < MIN_C) begin
      code_o  = MIN_C;
      clamp_o = 1'b1;
    end else if (raw_q > MAX_C) begin
      code_o  = MAX_C;
      clamp_o = 1'b1;
    end
  end

  assign db_o   = code_o - OFF_C;
  assign full_o = full_q;
endmodule

// File: rtl/serial_gain_port.sv
module serial_gain_port #(
  parameter int unsigned WORD_W = sgc_pkg::WORD_W_DEF,
  parameter int unsigned CODE_MIN = sgc_pkg::CODE_MIN_DEF,
  parameter int unsigned CODE_MAX = sgc_pkg::CODE_MAX_DEF,
  parameter int unsigned DB_OFFSET = sgc_pkg::DB_OFFSET_DEF,
  parameter int unsigned SYNC_STAGES = sgc_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              load_ni,
  input  logic              tx_en_i,
  input  logic              sleep_ni,
  output logic [WORD_W-1:0] gain_code_o,
  output logic [WORD_W-1:0] gain_db_o,
  output logic              clamp_o,
  output logic              word_full_o,
  output logic [1:0]        pwr_state_o
);
  import sgc_pkg::*;

  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  // bit order: sleep_n, tx_en, load_n, sdata, sclk; idle strobe is high
  localparam logic [4:0] SYNC_RST = 5'b00100;

  logic [4:0] raw_in, sync_q;
  logic       sclk_s, sdata_s, load_s, tx_s, sleep_s;
  logic       sclk_prev_q, load_prev_q;
  logic       sclk_rise, load_rise, load_fall, shift_en;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;
  pwr_state_e pwr_state;

  assign raw_in = {sleep_ni, tx_en_i, load_ni, sdata_i, sclk_i};

  sgc_sync #(.N(5), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_q)
  );

  assign {sleep_s, tx_s, load_s, sdata_s, sclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      load_prev_q <= load_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign load_rise = load_s & ~load_prev_q;
  assign load_fall = ~load_s & load_prev_q;
  // a strobe already high gates the coincident clock edge
  assign shift_en  = sclk_rise & ~load_s;

  sgc_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .clear_i(load_fall),
    .bit_i  (sdata_s),
    .word_o (word),
    .count_o(bit_cnt)
  );

  sgc_latch #(
    .WORD_W(WORD_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .DB_OFFSET(DB_OFFSET)
  ) i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_rise),
    .word_i (word),
    .full_i (bit_cnt == CNT_FULL),
    .code_o (gain_code_o),
    .db_o   (gain_db_o),
    .clamp_o(clamp_o),
    .full_o (word_full_o)
  );

  always_comb begin
    if (!sleep_s)   pwr_state = PWR_SLEEP;
    else if (!tx_s) pwr_state = PWR_TX_OFF;
    else            pwr_state = PWR_TX_ON;
  end
  assign pwr_state_o = pwr_state;
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned CODE_MIN = 1,
  parameter int unsigned CODE_MAX = 60
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_rise,
  input logic              shift_en,
  input logic              load_s,
  input logic [WORD_W-1:0] gain_code_o,
  input logic [WORD_W-1:0] gain_db_o,
  input logic              clamp_o,
  input logic              word_full_o,
  input logic [1:0]        pwr_state_o
);
  localparam logic [WORD_W-1:0] MIN_C = WORD_W'(CODE_MIN);
  localparam logic [WORD_W-1:0] MAX_C = WORD_W'(CODE_MAX);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_rise |=> $stable(gain_code_o) && $stable(gain_db_o));

  p_code_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_code_o >= MIN_C && gain_code_o <= MAX_C);

  p_clamp_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> (gain_code_o == MIN_C || gain_code_o == MAX_C));

  p_full_on_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_full_o) |-> $past(load_rise));

  p_no_shift_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_s |-> !shift_en);

  p_pwr_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o != 2'b11);
endmodule

bind serial_gain_port sgc_checker #(
  .WORD_W(WORD_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
) i_sgc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_rise  (load_rise),
  .shift_en   (shift_en),
  .load_s     (load_s),
  .gain_code_o(gain_code_o),
  .gain_db_o  (gain_db_o),
  .clamp_o    (clamp_o),
  .word_full_o(word_full_o),
  .pwr_state_o(pwr_state_o)
);

// File: tb/test_serial_gain_port.sv
module test_serial_gain_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, load_n = 1'b1, tx_en = 1'b0, sleep_n = 1'b0;
  logic [7:0] code, db;
  logic clamp, full;
  logic [1:0] pwr;
  int errors = 0, checks = 0;
  logic [7:0] sr_m = 8'h00;
  logic [7:0] applied_m = 8'd1;
  bit done = 0;

  always #4 clk = ~clk;

  serial_gain_port i_serial_gain_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .load_ni(load_n),
    .tx_en_i(tx_en), .sleep_ni(sleep_n), .gain_code_o(code), .gain_db_o(db),
    .clamp_o(clamp), .word_full_o(full), .pwr_state_o(pwr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [7:0] w);
    if (w < 8'd1) return 1;
    if (w > 8'd60) return 60;
    return int'(w);
  endfunction

  task automatic check_applied(input string req, input logic [7:0] w, input int exp_full);
    check(req, int'(code), exp_code(w));
    check(req, int'($signed(db)), exp_code(w) - 29);
    check(req, int'(clamp), (w < 8'd1 || w > 8'd60) ? 1 : 0);
    check(req, int'(full), exp_full);
  endtask

  // shifts n bits MSB-first from bits[n-1]; strobe must already be low
  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      sr_m = {sr_m[6:0], bits[i]};
    end
  endtask

  task automatic write_word(input string req, input logic [15:0] bits, input int n);
    load_n = 1'b0;
    tick(4);
    shift_bits(bits, n);
    tick(4);
    check("R3", int'(code), exp_code(applied_m));
    load_n = 1'b1;
    tick(6);
    applied_m = sr_m;
    check_applied(req, sr_m, (n == 8) ? 1 : 0);
  endtask

  task automatic t_reset;
    check("R1", int'(code), 1);
    check("R1", int'($signed(db)), -28);
    check("R1", int'(clamp), 0);
    check("R1", int'(full), 0);
  endtask

  task automatic t_words;
    write_word("R2", 16'h002A, 8);
    write_word("R2", 16'h003C, 8);
    write_word("R6", 16'h0001, 8);
    write_word("R6", 16'h001D, 8);
  endtask

  task automatic t_clamp;
    write_word("R5", 16'h0000, 8);
    write_word("R5", 16'h003D, 8);
    write_word("R5", 16'h00FF, 8);
    write_word("R5", 16'h003C, 8);
  endtask

  task automatic t_ignore_high;
    write_word("R4", 16'h002D, 8);
    for (int i = 0; i < 3; i++) begin
      sdata = 1'b1;
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    load_n = 1'b0;
    tick(8);
    load_n = 1'b1;
    tick(6);
    check_applied("R4", 8'h2D, 0);
  endtask

  task automatic t_partial;
    write_word("R7", 16'h0005, 3);
    write_word("R7", 16'h0000, 0);
    write_word("R7", 16'h0219, 10);
    write_word("R8", 16'h0011, 8);
  endtask

  task automatic t_collide;
    load_n = 1'b0;
    tick(4);
    shift_bits(16'h0015, 7);
    sdata = 1'b1;
    tick(4);
    sclk = 1'b1;
    load_n = 1'b1;
    tick(4);
    sclk = 1'b0;
    tick(4);
    applied_m = sr_m;
    check_applied("R10", sr_m, 0);
  endtask

  task automatic t_power;
    sleep_n = 1'b0; tx_en = 1'b1; tick(4);
    check("R9", int'(pwr), 0);
    sleep_n = 1'b1; tx_en = 1'b0; tick(4);
    check("R9", int'(pwr), 1);
    tx_en = 1'b1; tick(4);
    check("R9", int'(pwr), 2);
    sleep_n = 1'b0; tick(4);
    check("R9", int'(pwr), 0);
    sleep_n = 1'b1; tx_en = 1'b0; tick(4);
    check("R9", int'(pwr), 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_words();
    t_clamp();
    t_ignore_high();
    t_partial();
    t_collide();
    t_power();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule